// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer

This block holds the program counter and the fetch control of a five-stage in-order pipeline whose stages are fetch, decode, execute, memory access and write-back. One instruction enters fetch on every cycle. The block also holds the address and valid flag of the instruction now in decode. Decode logic outside the block reports whether that instruction is a conditional branch, whether it is the delayed kind, whether its condition holds, and its target. The block uses these to choose the next fetch address and to tell decode when the instruction it holds must be squashed.

Branches are resolved in decode. When a branch sits in decode, the instruction at the next sequential address is already being fetched. For a delayed branch that following instruction, the delay slot, always completes. A taken delayed branch therefore runs the slot first and the target right after it, so it costs one apparent cycle. For a non-delayed branch that is taken, the slot instruction is cancelled and leaves a one-cycle bubble. Placing a branch in the delay slot of a delayed branch is illegal. The block flags it and lets that instruction complete as a no-op.

Top module: `fetch_sequencer`

## Requirements
- R1: While reset is high, and at the first clock edge after it, fetchAddr equals the reset vector (default 0x100). fetchValid, idValid, idCancel and errNestedBranch are all low.
- R2: When no taken branch acts, fetchAddr grows by 2 every cycle. Each fetched address appears on idAddr, with idValid high, one cycle after it was on fetchAddr.
- R3: A branch acts when idValid is high, idCancel is low and idBranch is high, and the instruction is not in a delay slot. If such a branch has idCondTrue high, fetchAddr equals idTarget in the next cycle.
- R4: After an acting delayed branch (idDelayed high), idCancel stays low for the following instruction. When the branch is taken, the completed order is branch, slot, then target.
- R5: A delayed branch with idCondTrue low leaves the completed order the same as the written order: branch, slot, next sequential instruction.
- R6: An acting non-delayed branch (idDelayed low) with idCondTrue high raises idCancel for exactly one cycle, while the slot instruction is in decode. The completed order is branch, then target. Any branch fields of the cancelled instruction have no effect.
- R7: A non-delayed branch with idCondTrue low raises no cancel. The instruction after it completes as an ordinary instruction and may itself be an acting branch.
- R8: A branch in decode that occupies the delay slot of an acting delayed branch drives errNestedBranch high in that same cycle. It causes no redirect and no cancel, and it completes as a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idBranch | input | 1 | Instruction in decode is a conditional branch |
| idDelayed | input | 1 | That branch is the delayed kind |
| idCondTrue | input | 1 | Resolved branch condition |
| idTarget | input | 32 | Branch target address |
| fetchAddr | output | 32 | Address fetched this cycle |
| fetchValid | output | 1 | fetchAddr carries a real fetch |
| idAddr | output | 32 | Address of the instruction in decode |
| idValid | output | 1 | Decode holds a fetched instruction |
| idCancel | output | 1 | Squash the instruction in decode |
| errNestedBranch | output | 1 | Branch found in a delay slot |

## Verification
The hardest situations to reach from the ports are those where the instruction following a branch is itself a branch. Each one has to be handled according to how its predecessor was resolved. The bench's instruction lookup places a second branch right behind the first in three ways. Behind a taken non-delayed branch the second branch must be ignored because it is cancelled. Behind a not-taken non-delayed branch it must act. Behind a taken delayed branch it must raise the error flag and do nothing. A behavioural reference trace for each program is compared against every completed instruction.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;

  // Strobes from control to the address datapath
  typedef struct packed {
    logic advance;   // a fetch happens this cycle
    logic redirect;  // next fetch comes from the branch target
  } fetchStrobe_t;

endpackage

// File: rtl/fetch_seq_ctrl.sv
module fetch_seq_ctrl
  import fetch_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         idBranch,
  input  logic         idDelayed,
  input  logic         idCondTrue,
  output fetchStrobe_t strobe,
  output logic         fetchValid,
  output logic         idValid,
  output logic         idCancel,
  output logic         errNested
);

  logic inSlot;       // decode holds the slot of a delayed branch
  logic live;         // decode holds an instruction that will complete
  logic acting;       // a legal branch is being resolved
  logic takeNow;

  assign live      = idValid && !idCancel;
  assign acting    = live && idBranch && !inSlot;
  assign errNested = live && idBranch && inSlot;
  assign takeNow   = acting && idCondTrue;

  always_comb begin
    strobe          = '0;
    strobe.advance  = fetchValid;
    strobe.redirect = takeNow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetchValid <= 1'b0;
      idValid    <= 1'b0;
      idCancel   <= 1'b0;
      inSlot     <= 1'b0;
    end else begin
      fetchValid <= 1'b1;
      idValid    <= fetchValid;
      idCancel   <= takeNow && !idDelayed;
      inSlot     <= acting && idDelayed;
    end
  end

  AST_SLOT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (live && idBranch && idDelayed && !errNested) |=> !idCancel); // R4

  AST_CANCEL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    idCancel |=> !idCancel); // R6

  AST_CANCEL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    idCancel |-> $past(idBranch && !idDelayed && idCondTrue)); // R6

  AST_NESTED_NO_CANCEL: assert property (@(posedge clk) disable iff (rst)
    errNested |=> !idCancel); // R8

  AST_NOT_TAKEN_NO_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (live && idBranch && !idCondTrue) |=> !idCancel); // R7

endmodule

// File: rtl/fetch_seq_dp.sv
module fetch_seq_dp
  import fetch_seq_pkg::*;
#(
  parameter int              ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] RESET_VECTOR = 32'h0000_0100,
  parameter int              PC_STEP      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  fetchStrobe_t      strobe,
  input  logic [ADDR_W-1:0] idTarget,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] idAddr
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

  logic [ADDR_W-1:0] pcNext;

  always_comb begin
    if (strobe.redirect)     pcNext = idTarget;
    else if (strobe.advance) pcNext = pc + STEP;
    else                     pcNext = pc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= RESET_VECTOR;
      idAddr <= '0;
    end else begin
      pc <= pcNext;
      if (strobe.advance) idAddr <= pc;
    end
  end

  AST_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (rst)
    strobe.redirect |=> (pc == $past(idTarget))); // R3

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (strobe.advance && !strobe.redirect) |=> (pc == $past(pc) + STEP)); // R2

  AST_ID_FOLLOWS_FETCH: assert property (@(posedge clk) disable iff (rst)
    strobe.advance |=> (idAddr == $past(pc))); // R2

endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer
  import fetch_seq_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] RESET_VECTOR = 32'h0000_0100,
  parameter int                PC_STEP      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idBranch,
  input  logic              idDelayed,
  input  logic              idCondTrue,
  input  logic [ADDR_W-1:0] idTarget,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchValid,
  output logic [ADDR_W-1:0] idAddr,
  output logic              idValid,
  output logic              idCancel,
  output logic              errNestedBranch
);

  fetchStrobe_t strobe;

  fetch_seq_ctrl i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .idBranch   (idBranch),
    .idDelayed  (idDelayed),
    .idCondTrue (idCondTrue),
    .strobe     (strobe),
    .fetchValid (fetchValid),
    .idValid    (idValid),
    .idCancel   (idCancel),
    .errNested  (errNestedBranch)
  );

  fetch_seq_dp #(
    .ADDR_W       (ADDR_W),
    .RESET_VECTOR (RESET_VECTOR),
    .PC_STEP      (PC_STEP)
  ) i_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .idTarget (idTarget),
    .pc       (fetchAddr),
    .idAddr   (idAddr)
  );

  AST_NESTED_NO_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    errNestedBranch |=> (fetchAddr == $past(fetchAddr) + ADDR_W'(PC_STEP))); // R8

endmodule

// File: tb/test_fetch_sequencer.sv
module test_fetch_sequencer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        idBranch, idDelayed, idCondTrue;
  logic [31:0] idTarget;
  logic [31:0] fetchAddr, idAddr;
  logic        fetchValid, idValid, idCancel, errNestedBranch;

  int checks = 0;
  int fails  = 0;
  int scen   = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_sequencer i_fetch_sequencer (
    .clk(clk), .rst(rst), .idBranch(idBranch), .idDelayed(idDelayed),
    .idCondTrue(idCondTrue), .idTarget(idTarget), .fetchAddr(fetchAddr),
    .fetchValid(fetchValid), .idAddr(idAddr), .idValid(idValid),
    .idCancel(idCancel), .errNestedBranch(errNestedBranch)
  );

  // Combinational program lookup: decoded fields for the address in decode
  always_comb begin
    idBranch = 0; idDelayed = 0; idCondTrue = 0; idTarget = '0;
    case (scen)
      0: if (idAddr == 32'h104) begin idBranch = 1; idDelayed = 1; idCondTrue = 1; idTarget = 32'h140; end
      1: if (idAddr == 32'h104) begin idBranch = 1; idDelayed = 1; idCondTrue = 0; idTarget = 32'h140; end
      2: begin
           if (idAddr == 32'h104) begin idBranch = 1; idCondTrue = 1; idTarget = 32'h140; end
           if (idAddr == 32'h106) begin idBranch = 1; idCondTrue = 1; idTarget = 32'h180; end
         end
      3: begin
           if (idAddr == 32'h104) begin idBranch = 1; idCondTrue = 0; idTarget = 32'h140; end
           if (idAddr == 32'h106) begin idBranch = 1; idDelayed = 1; idCondTrue = 1; idTarget = 32'h160; end
         end
      default: begin
           if (idAddr == 32'h104) begin idBranch = 1; idDelayed = 1; idCondTrue = 1; idTarget = 32'h140; end
           if (idAddr == 32'h106) begin idBranch = 1; idDelayed = 1; idCondTrue = 1; idTarget = 32'h180; end
         end
    endcase
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runScenario(int s, string req, logic [31:0] trace [8],
                             int expCancel, int expErr);
    logic [31:0] expQ [$];
    int cancels = 0;
    int errs    = 0;
    for (int i = 0; i < 8; i++) expQ.push_back(trace[i]);
    @(negedge clk);
    scen = s;
    rst  = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 fetchAddr", fetchAddr, 32'h100);
    check("R1 flags", {28'd0, fetchValid, idValid, idCancel, errNestedBranch}, 32'd0);
    rst = 1'b0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (idCancel) cancels++;
      if (errNestedBranch) errs++;
      if (idValid && !idCancel && expQ.size() > 0)
        check(req, idAddr, expQ.pop_front());
    end
    check({req, " trace length"}, 32'(expQ.size()), 32'd0);
    check("R6 cancel count", 32'(cancels), 32'(expCancel));
    check("R8 error count", 32'(errs), 32'(expErr));
  endtask

  initial begin
    logic [31:0] tr [8];
    tr = '{32'h100, 32'h102, 32'h104, 32'h106, 32'h140, 32'h142, 32'h144, 32'h146};
    runScenario(0, "R4 taken delayed", tr, 0, 0);
    tr = '{32'h100, 32'h102, 32'h104, 32'h106, 32'h108, 32'h10A, 32'h10C, 32'h10E};
    runScenario(1, "R5 not-taken delayed", tr, 0, 0);
    tr = '{32'h100, 32'h102, 32'h104, 32'h140, 32'h142, 32'h144, 32'h146, 32'h148};
    runScenario(2, "R6 taken non-delayed", tr, 1, 0);
    tr = '{32'h100, 32'h102, 32'h104, 32'h106, 32'h108, 32'h160, 32'h162, 32'h164};
    runScenario(3, "R7 not-taken non-delayed", tr, 0, 0);
    tr = '{32'h100, 32'h102, 32'h104, 32'h106, 32'h140, 32'h142, 32'h144, 32'h146};
    runScenario(4, "R8 nested in slot", tr, 0, 1);
    // R2 and R3: after the redirect of the last run, fetch keeps stepping by 2
    @(negedge clk);
    begin
      logic [31:0] a0;
      a0 = fetchAddr;
      @(negedge clk);
      check("R2 step", fetchAddr, a0 + 32'd2);
      check("R3 valid", {31'd0, fetchValid}, 32'd1);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule